// File: doc/BRIEF.md
# Shared-Memory Command Ring Consumer

This block sits on the accelerator side of a command ring kept in shared memory. The consumer and head index, the producer and tail index, and a set of fixed-size command slots are all ordinary memory words. The block reaches them through a single master port. Each request on that port is a single-word read or write and gets exactly one response. A start pulse sets the block running. It reads its head index once. It then reads the tail index to find out whether the ring holds work, and waits a programmable number of cycles between polls while the ring is empty.

When a slot is occupied, the block reads the slot's words one at a time, lowest word first. It presents the whole command to a compute back end over a valid/ready handshake. It then waits until the back end reports that the command's result writes are complete, and only then stores the advanced head index back to memory. A producer that sees the ring empty therefore knows that every earlier command has finished.

The block repeats this loop until it fetches a command whose opcode marks the end of the stream. That command is removed from the ring like any other command but is never handed to the back end. After that the block raises a sticky completion flag and stays silent on the memory port.

Top module: `cmdring_consumer`

## Requirements
- R1: After reset, `mem_req_valid`, `cmd_valid` and `done` are low, and no memory request is made until a `start` pulse arrives.
- R2: At most one memory request is outstanding at a time, and each request gets one response before the next request is issued. While a request waits for `mem_req_ready`, the request's address, direction and write data stay unchanged.
- R3: Occupancy is (tail − head) modulo SLOT_COUNT, where tail is the value read from word address TAIL_ADDR. When the occupancy is zero, at least `poll_gap` cycles pass before the tail index is read again.
- R4: A slot is fetched from word addresses RING_BASE + head·SLOT_WORDS + k, for k = 0 up to SLOT_WORDS−1 in ascending order. Word k appears on `cmd_data[k·DATA_W +: DATA_W]`. The command is offered only after all of its words have arrived.
- R5: Commands reach the back end in the order they were enqueued. The head index wraps from SLOT_COUNT−1 to 0.
- R6: While `cmd_valid` waits for `cmd_ready`, it stays high and `cmd_data` stays unchanged.
- R7: The only write the block makes is to word address HEAD_ADDR, with the value (head+1) modulo SLOT_COUNT. That write is issued only after `cmd_done` has been received for every command handed to the back end.
- R8: A command whose word 0 bits [7:0] equal END_OPC is never offered to the back end. Its slot is still released by a head write, which leaves the ring empty, and `done` is then raised.
- R9: Once `done` is high, it stays high and no memory request or command is issued until reset.
- R10: After `start`, the first request is a read of HEAD_ADDR, and the value it returns becomes the initial head index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins the consume loop |
| poll_gap | input | POLL_W | Minimum number of idle cycles between tail polls on an empty ring |
| mem_req_valid | output | 1 | Memory request is present |
| mem_req_ready | input | 1 | Memory accepts the request this cycle |
| mem_req_write | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W | Word address |
| mem_req_wdata | output | DATA_W | Write data |
| mem_rsp_valid | input | 1 | Response to the outstanding request |
| mem_rsp_rdata | input | DATA_W | Read data |
| cmd_valid | output | 1 | A fetched command is offered to the back end |
| cmd_ready | input | 1 | Back end takes the command |
| cmd_data | output | SLOT_WORDS·DATA_W | Command slot image, word 0 in the low bits |
| cmd_done | input | 1 | Pulse: result writes of the accepted command are complete |
| done | output | 1 | Sticky: end opcode consumed |

## Verification
The bench first leaves the ring empty after start. This separates correct polling at the programmed interval from a design that hammers the tail word or fetches garbage. Next it enqueues a short burst with a fast back end, which shows in-order delivery and per-word slot layout. It then fills the ring to capacity behind a slow back end and follows with the end command. This drives the head across the wrap point, and it exposes any head write-back that runs ahead of `cmd_done`. It also shows whether the end opcode leaks to the back end, leaves the ring non-empty, or is followed by further memory traffic. The ring starts at a non-zero index, which catches a design that assumes head starts at zero instead of reading it.

// File: rtl/cmdring_pkg.sv
package cmdring_pkg;

    localparam int OPC_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_HEAD_REQ,
        ST_HEAD_RSP,
        ST_TAIL_REQ,
        ST_TAIL_RSP,
        ST_WAIT,
        ST_FETCH_REQ,
        ST_FETCH_RSP,
        ST_ISSUE,
        ST_EXEC,
        ST_HEADW_REQ,
        ST_HEADW_RSP,
        ST_DONE
    } ring_state_e;

    function automatic logic is_terminator(input logic [OPC_W-1:0] opc,
                                           input logic [OPC_W-1:0] end_code);
        return opc == end_code;
    endfunction

endpackage

// File: rtl/cmdring_occupancy.sv
module cmdring_occupancy #(
    parameter int SLOT_COUNT = 8,
    localparam int PTR_W = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1
) (
    input  logic [PTR_W-1:0] head,
    input  logic [PTR_W-1:0] tail,
    output logic [PTR_W:0]   occ,
    output logic [PTR_W-1:0] head_next
);
    localparam logic [PTR_W:0] SLOTS = (PTR_W+1)'(SLOT_COUNT);

    always_comb begin
        if (tail >= head) occ = {1'b0, tail} - {1'b0, head};
        else              occ = {1'b0, tail} + SLOTS - {1'b0, head};
        head_next = (head == PTR_W'(SLOT_COUNT - 1)) ? '0 : head + 1'b1;
    end
endmodule

// File: rtl/cmdring_slot_buf.sv
module cmdring_slot_buf #(
    parameter int DATA_W     = 32,
    parameter int SLOT_WORDS = 3,
    localparam int IDX_W = (SLOT_WORDS > 1) ? $clog2(SLOT_WORDS) : 1
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         load,
    input  logic [DATA_W-1:0]            word_in,
    output logic [IDX_W-1:0]             idx,
    output logic                         last,
    output logic [SLOT_WORDS*DATA_W-1:0] slot_out
);
    assign last = (idx == IDX_W'(SLOT_WORDS - 1));

    always_ff @(posedge clk) begin
        if (rst)       idx <= '0;
        else if (load) idx <= last ? '0 : idx + 1'b1;
    end

    for (genvar k = 0; k < SLOT_WORDS; k++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)                              slot_out[k*DATA_W +: DATA_W] <= '0;
            else if (load && idx == IDX_W'(k))    slot_out[k*DATA_W +: DATA_W] <= word_in;
        end
    end
endmodule

// File: rtl/cmdring_poll_timer.sv
module cmdring_poll_timer #(
    parameter int POLL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arm,
    input  logic              run,
    input  logic [POLL_W-1:0] gap,
    output logic              expired
);
    logic [POLL_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                      cnt_q <= '0;
        else if (arm)                 cnt_q <= gap;
        else if (run && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cmdring_consumer.sv
module cmdring_consumer
    import cmdring_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int SLOT_WORDS = 3,
    parameter int SLOT_COUNT = 8,
    parameter int POLL_W     = 8,
    parameter int HEAD_ADDR  = 0,
    parameter int TAIL_ADDR  = 1,
    parameter int RING_BASE  = 16,
    parameter logic [7:0] END_OPC = 8'hFF
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [POLL_W-1:0]            poll_gap,
    output logic                         mem_req_valid,
    input  logic                         mem_req_ready,
    output logic                         mem_req_write,
    output logic [ADDR_W-1:0]            mem_req_addr,
    output logic [DATA_W-1:0]            mem_req_wdata,
    input  logic                         mem_rsp_valid,
    input  logic [DATA_W-1:0]            mem_rsp_rdata,
    output logic                         cmd_valid,
    input  logic                         cmd_ready,
    output logic [SLOT_WORDS*DATA_W-1:0] cmd_data,
    input  logic                         cmd_done,
    output logic                         done
);
    localparam int PTR_W = (SLOT_COUNT > 1) ? $clog2(SLOT_COUNT) : 1;
    localparam int IDX_W = (SLOT_WORDS > 1) ? $clog2(SLOT_WORDS) : 1;

    ring_state_e       state_q, state_d;
    logic [PTR_W-1:0]  head_q, head_next, rsp_ptr;
    logic [PTR_W:0]    occ;
    logic              end_q;
    logic              req_fire, buf_load, buf_last, wait_over, arm_poll;
    logic [IDX_W-1:0]  buf_idx;
    logic              unused_rdata_hi;

    assign rsp_ptr         = mem_rsp_rdata[PTR_W-1:0];
    assign unused_rdata_hi = ^mem_rsp_rdata[DATA_W-1:PTR_W];
    assign req_fire        = mem_req_valid && mem_req_ready;
    assign buf_load        = (state_q == ST_FETCH_RSP) && mem_rsp_valid;
    assign arm_poll        = (state_q == ST_TAIL_RSP) && mem_rsp_valid;

    cmdring_occupancy #(.SLOT_COUNT(SLOT_COUNT)) u_occ (
        .head(head_q), .tail(rsp_ptr), .occ(occ), .head_next(head_next)
    );

    cmdring_slot_buf #(.DATA_W(DATA_W), .SLOT_WORDS(SLOT_WORDS)) u_slot (
        .clk(clk), .rst(rst), .load(buf_load), .word_in(mem_rsp_rdata),
        .idx(buf_idx), .last(buf_last), .slot_out(cmd_data)
    );

    cmdring_poll_timer #(.POLL_W(POLL_W)) u_poll (
        .clk(clk), .rst(rst), .arm(arm_poll), .run(state_q == ST_WAIT),
        .gap(poll_gap), .expired(wait_over)
    );

    // Memory request generation, held steady by the registered state
    always_comb begin
        mem_req_valid = 1'b0;
        mem_req_write = 1'b0;
        mem_req_addr  = '0;
        mem_req_wdata = '0;
        unique case (state_q)
            ST_HEAD_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ADDR_W'(HEAD_ADDR);
            end
            ST_TAIL_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ADDR_W'(TAIL_ADDR);
            end
            ST_FETCH_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = ADDR_W'(RING_BASE) + ADDR_W'(head_q) * ADDR_W'(SLOT_WORDS)
                              + ADDR_W'(buf_idx);
            end
            ST_HEADW_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_write = 1'b1;
                mem_req_addr  = ADDR_W'(HEAD_ADDR);
                mem_req_wdata = DATA_W'(head_next);
            end
            default: ;
        endcase
    end

    assign cmd_valid = (state_q == ST_ISSUE) && !end_q;
    assign done      = (state_q == ST_DONE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)         state_d = ST_HEAD_REQ;
            ST_HEAD_REQ:  if (req_fire)      state_d = ST_HEAD_RSP;
            ST_HEAD_RSP:  if (mem_rsp_valid) state_d = ST_TAIL_REQ;
            ST_TAIL_REQ:  if (req_fire)      state_d = ST_TAIL_RSP;
            ST_TAIL_RSP:  if (mem_rsp_valid) state_d = (occ == '0) ? ST_WAIT : ST_FETCH_REQ;
            ST_WAIT:      if (wait_over)     state_d = ST_TAIL_REQ;
            ST_FETCH_REQ: if (req_fire)      state_d = ST_FETCH_RSP;
            ST_FETCH_RSP: if (mem_rsp_valid) state_d = buf_last ? ST_ISSUE : ST_FETCH_REQ;
            ST_ISSUE: begin
                if (end_q)          state_d = ST_HEADW_REQ;
                else if (cmd_ready) state_d = ST_EXEC;
            end
            ST_EXEC:      if (cmd_done)      state_d = ST_HEADW_REQ;
            ST_HEADW_REQ: if (req_fire)      state_d = ST_HEADW_RSP;
            ST_HEADW_RSP: if (mem_rsp_valid) state_d = end_q ? ST_DONE : ST_TAIL_REQ;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            head_q  <= '0;
            end_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_HEAD_RSP && mem_rsp_valid)
                head_q <= rsp_ptr;
            if (state_q == ST_HEADW_RSP && mem_rsp_valid)
                head_q <= head_next;
            if (buf_load && buf_idx == '0)
                end_q <= is_terminator(mem_rsp_rdata[OPC_W-1:0], END_OPC);
        end
    end
endmodule

// File: rtl/cmdring_consumer_checker.sv
module cmdring_consumer_checker #(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 12,
    parameter int SLOT_WORDS = 3
) (
    input logic                         clk,
    input logic                         rst,
    input logic                         start,
    input logic                         mem_req_valid,
    input logic                         mem_req_ready,
    input logic                         mem_req_write,
    input logic [ADDR_W-1:0]            mem_req_addr,
    input logic [DATA_W-1:0]            mem_req_wdata,
    input logic                         mem_rsp_valid,
    input logic                         cmd_valid,
    input logic                         cmd_ready,
    input logic [SLOT_WORDS*DATA_W-1:0] cmd_data,
    input logic                         cmd_done,
    input logic                         done
);
    logic       outstanding_q;
    logic       started_q;
    logic [3:0] inflight_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            outstanding_q <= 1'b0;
            started_q     <= 1'b0;
            inflight_q    <= '0;
        end else begin
            if (start) started_q <= 1'b1;
            if (mem_req_valid && mem_req_ready) outstanding_q <= 1'b1;
            else if (mem_rsp_valid)             outstanding_q <= 1'b0;
            if (cmd_valid && cmd_ready)             inflight_q <= inflight_q + 1'b1;
            else if (cmd_done && inflight_q != '0)  inflight_q <= inflight_q - 1'b1;
        end
    end

    assert_quiet_before_start_R1: assert property (@(posedge clk) disable iff (rst)
        !started_q |-> !mem_req_valid);

    assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_ready) |-> !outstanding_q);

    assert_req_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
             && $stable(mem_req_wdata)));

    assert_cmd_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    assert_head_after_done_R7: assert property (@(posedge clk) disable iff (rst)
        (mem_req_valid && mem_req_write) |-> (inflight_q == '0));

    assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> done);

    assert_done_silent_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!mem_req_valid && !cmd_valid));
endmodule

bind cmdring_consumer cmdring_consumer_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SLOT_WORDS(SLOT_WORDS)
) u_checker (
    .clk(clk), .rst(rst), .start(start),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_data(cmd_data),
    .cmd_done(cmd_done), .done(done)
);

// File: tb/cmdring_consumer_bench.sv
module cmdring_consumer_bench;
    localparam int DW = 32, AW = 12, SW = 3, SC = 8, PW = 8;
    localparam int HA = 0, TA = 1, RB = 16, PG = 20;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [PW-1:0] poll_gap = PW'(PG);
    logic mem_req_valid, mem_req_ready, mem_req_write, mem_rsp_valid;
    logic [AW-1:0] mem_req_addr;
    logic [DW-1:0] mem_req_wdata, mem_rsp_rdata;
    logic cmd_valid, cmd_ready, cmd_done, done;
    logic [SW*DW-1:0] cmd_data;

    cmdring_consumer #(.DATA_W(DW), .ADDR_W(AW), .SLOT_WORDS(SW), .SLOT_COUNT(SC),
        .POLL_W(PW), .HEAD_ADDR(HA), .TAIL_ADDR(TA), .RING_BASE(RB), .END_OPC(8'hFF))
    u_cmdring_consumer (
        .clk(clk), .rst(rst), .start(start), .poll_gap(poll_gap),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_data(cmd_data), .cmd_done(cmd_done), .done(done)
    );

    always #5 clk = ~clk;

    int unsigned cyc = 0;
    initial forever begin
        @(posedge clk);
        cyc = cyc + 1;
    end

    logic [DW-1:0]    mem [0:63];
    logic [SW*DW-1:0] exp_q [$];
    int checks = 0, errors = 0;
    int req_count = 0, cmd_seen = 0, head_writes = 0, inflight = 0, shadow_head = 2;
    int first_addr = -1;
    bit slow_be = 1'b0, last_tail_empty = 1'b0;
    int unsigned last_tail_t = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Memory model: one-cycle response latency, periodic ready stalls
    initial begin
        bit pend;
        logic [DW-1:0] pend_data;
        pend = 1'b0;
        pend_data = '0;
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b0;
        mem_rsp_rdata = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = pend;
            mem_rsp_rdata = pend ? pend_data : '0;
            pend = 1'b0;
            mem_req_ready = (cyc % 4) != 3;
            if (!rst && mem_req_valid && mem_req_ready) begin
                req_count++;
                pend = 1'b1;
                if (first_addr < 0) first_addr = int'(mem_req_addr);
                if (mem_req_write) begin
                    head_writes++;
                    check(mem_req_addr == AW'(HA), "R7", "write address", mem_req_addr, HA);
                    check(mem_req_wdata == DW'((shadow_head + 1) % SC), "R7", "head value",
                          mem_req_wdata, (shadow_head + 1) % SC);
                    check(inflight == 0, "R7", "head write before cmd_done", inflight, 0);
                    shadow_head = (shadow_head + 1) % SC;
                    mem[HA] = mem_req_wdata;
                    pend_data = '0;
                end else begin
                    pend_data = mem[mem_req_addr[5:0]];
                    if (mem_req_addr == AW'(TA)) begin
                        if (last_tail_empty)
                            check(cyc - last_tail_t >= PG, "R3", "poll spacing",
                                  cyc - last_tail_t, PG);
                        last_tail_t = cyc;
                        last_tail_empty = (mem[TA] == mem[HA]);
                    end
                end
            end
        end
    end

    // Back end model and scoreboard monitor
    initial begin
        bit busy;
        int cnt;
        busy = 1'b0;
        cnt = 0;
        cmd_ready = 1'b0;
        cmd_done = 1'b0;
        forever begin
            @(negedge clk);
            cmd_done = 1'b0;
            if (busy) begin
                if (cnt == 0) begin
                    cmd_done = 1'b1;
                    busy = 1'b0;
                    inflight--;
                end else cnt--;
            end
            cmd_ready = !busy && (slow_be ? ((cyc % 5) == 0) : 1'b1);
            if (!rst && cmd_valid && cmd_ready) begin
                cmd_seen++;
                inflight++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8", "unexpected command offered", cmd_data, 0);
                end else begin
                    logic [SW*DW-1:0] e;
                    e = exp_q.pop_front();
                    check(cmd_data == e, "R5", "command order/content (R4 layout)", cmd_data, e);
                end
                busy = 1'b1;
                cnt = 2 + (cmd_seen % 4);
            end
        end
    end

    // Host-side driver: writes a slot, pushes the expected image, bumps tail
    task automatic enqueue(input logic [7:0] opc, input bit expect_it);
        int t;
        logic [SW*DW-1:0] img;
        while (((int'(mem[TA]) + 1) % SC) == int'(mem[HA])) @(negedge clk);
        t = int'(mem[TA]);
        for (int k = 0; k < SW; k++) begin
            logic [DW-1:0] w;
            w = {opc, 8'(k), 8'hC3, opc};
            mem[RB + t * SW + k] = w;
            img[k*DW +: DW] = w;
        end
        if (expect_it) exp_q.push_back(img);
        mem[TA] = DW'((t + 1) % SC);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int rc;
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[HA] = 32'd2;
        mem[TA] = 32'd2;
        repeat (3) @(negedge clk);
        check(mem_req_valid == 1'b0, "R1", "reset mem_req_valid", mem_req_valid, 0);
        check(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);
        rst = 1'b0;
        repeat (10) @(negedge clk);
        check(req_count == 0, "R1", "requests before start", req_count, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (120) @(negedge clk);
        check(first_addr == HA, "R10", "first request address", first_addr, HA);

        for (int id = 1; id <= 3; id++) enqueue(8'(id), 1'b1);
        for (int i = 0; i < 3000; i++) begin
            if (mem[HA] == mem[TA] && exp_q.size() == 0 && inflight == 0) break;
            @(negedge clk);
        end
        check(cmd_seen == 3, "R5", "burst delivered", cmd_seen, 3);

        slow_be = 1'b1;
        for (int id = 4; id <= 10; id++) enqueue(8'(id), 1'b1);
        enqueue(8'hFF, 1'b0);
        for (int i = 0; i < 20000; i++) begin
            if (done) break;
            @(negedge clk);
        end
        check(done == 1'b1, "R8", "done after end", done, 1);
        check(mem[HA] == mem[TA], "R8", "ring empty after end", mem[HA], mem[TA]);
        check(exp_q.size() == 0, "R5", "all commands delivered", exp_q.size(), 0);
        check(cmd_seen == 10, "R8", "end not offered", cmd_seen, 10);
        check(head_writes == 11, "R7", "head write count", head_writes, 11);
        check(mem[HA] == 32'd5, "R5", "head wrapped", mem[HA], 5);

        rc = req_count;
        repeat (50) @(negedge clk);
        check(req_count == rc, "R9", "requests after done", req_count, rc);
        check(done == 1'b1, "R9", "done sticky", done, 1);
        check(cmd_valid == 1'b0, "R9", "no command after done", cmd_valid, 0);
        finish_run();
    end
endmodule